// File: doc/BRIEF.md
# Paged Byte-Store Access Controller

This block gives a host a byte-wide register port onto a small on-chip store that is only ever transferred one whole page at a time. A 32-byte buffer sits between the host and the store. To program a page, the host empties the buffer, pushes the page's bytes into the data port, selects a page and issues a write command. To fetch a page, the host selects a page and issues a read command. Once the transfer finishes, it pulls the bytes out of the data port. A single ready flag in the command/status register tells the host when the controller is free.

Programming is fenced by a separate write-mode register. An enable can cover many page writes, and it may be withdrawn as soon as a write has been issued. The store is modelled as an internal page-wide array. Page programming holds the controller busy for a parameterised number of cycles, and page fetch holds it busy for 32 cycles. A transfer that the host abandons part-way needs no explicit cleanup, because the next command clears the state it left behind.

Top module: `pgm_ctrl`

## Requirements
- R1: After reset the page register (offset 0) reads 0x00, command/status (offset 1) reads 0x80, write mode (offset 2) reads 0x00 and the data port (offset 3) reads 0x00; the page register reads back any byte written to it.
- R2: Status bit 7 is 1 when idle and 0 while busy; an accepted page write holds it 0 for WR_CYCLES (64) cycles and a page read for RD_CYCLES (32) cycles after the command cycle.
- R3: Command 0x01 with writing enabled copies the buffered bytes into the selected page in push order; the buffer is empty afterwards.
- R4: Command 0x02 loads the selected page into the buffer; 32 successive data-port reads return its bytes in order.
- R5: Command 0x00 empties the buffer; status bits 1:0 show the code of the last accepted command (01 write, 10 read) and are cleared by 0x00.
- R6: Write mode bit 0 gates programming; a write command with it clear is ignored (ready stays 1, page unchanged); clearing it after a write is issued does not harm that write.
- R7: Commands 0x01 and 0x02 with a page number above 231 are ignored: ready stays 1, the buffer and the store are untouched.
- R8: Any command written while busy is ignored, as is any command code other than 0x00, 0x01 and 0x02.
- R9: The page number is captured when a command is accepted; rewriting the page register while busy does not redirect the operation.
- R10: Data-port pushes beyond 32 bytes are dropped; data-port reads from an empty buffer return 0x00.
- R11: A read command discards whatever a partial transfer left behind before loading; a write command after a partial fill programs the pushed bytes followed by 0x00 in the unfilled slots.
- R12: While busy, data-port writes are ignored and data-port reads return 0x00 without consuming data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered, valid one cycle after rd_i |

## Verification
Read data is registered, so the bench strobes on one falling edge and takes the value on the next one, after the rising edge that loaded it. The controller goes busy at the rising edge that accepts a command. The bench polls status once per cycle, starting in the cycle after the command, and counts the zero ready bits. That count must equal the busy length minus any bus cycles the bench deliberately spent during the busy window. Every page is programmed and read back with arithmetic patterns. The ignored-command, overflow, empty-read and abort cases are each checked at the exact read that follows the stimulus.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    REG_PAGE = 2'd0,
    REG_CMD  = 2'd1,
    REG_MODE = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  localparam logic [DW-1:0] CMD_CLR = 8'h00;
  localparam logic [DW-1:0] CMD_WR  = 8'h01;
  localparam logic [DW-1:0] CMD_RD  = 8'h02;
endpackage

// File: rtl/pgm_fifo.sv
module pgm_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic [DEPTH*DW-1:0] load_data_i,
  input  logic                push_i,
  input  logic [DW-1:0]       push_data_i,
  input  logic                pop_i,
  output logic [DW-1:0]       pop_data_o,
  output logic [DEPTH*DW-1:0] flat_o,
  output logic [PW-1:0]       wptr_o,
  output logic [PW-1:0]       rptr_o
);
  logic [DEPTH*DW-1:0] buf_q;
  logic [PW-1:0]       wptr_q, rptr_q;
  logic                has_data, can_push;

  assign has_data = rptr_q < wptr_q;
  assign can_push = wptr_q < PW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      buf_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (load_i) begin
      buf_q  <= load_data_i;
      wptr_q <= PW'(DEPTH);
      rptr_q <= '0;
    end else begin
      if (push_i && can_push) begin
        buf_q[int'(wptr_q[IW-1:0])*DW +: DW] <= push_data_i;
        wptr_q <= wptr_q + 1'b1;
      end
      if (pop_i && has_data) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign pop_data_o = has_data ? buf_q[int'(rptr_q[IW-1:0])*DW +: DW] : '0;
  assign flat_o     = buf_q;
  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
endmodule

// File: rtl/pgm_store.sv
module pgm_store #(
  parameter int NUM_PAGES = 232,
  parameter int PAGE_BITS = 256,
  localparam int AW       = $clog2(NUM_PAGES)
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [PAGE_BITS-1:0] wdata_i,
  input  logic [AW-1:0]        raddr_i,
  output logic [PAGE_BITS-1:0] rdata_o
);
  // nonvolatile model: contents survive reset
  logic [PAGE_BITS-1:0] mem_q [NUM_PAGES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_pkg::*;
#(
  parameter int NUM_PAGES = 232,
  parameter int WR_CYCLES = 64,
  parameter int RD_CYCLES = 32,
  localparam int AW       = $clog2(NUM_PAGES),
  localparam int MAXC     = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES,
  localparam int CW       = $clog2(MAXC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_i,
  input  logic          wen_i,
  input  logic [DW-1:0] page_i,
  output logic          busy_o,
  output op_e           op_o,
  output logic [AW-1:0] page_o,
  output logic [1:0]    code_o,
  output logic          fifo_clr_o,
  output logic          fifo_load_o,
  output logic          store_we_o
);
  logic          busy_q;
  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] page_q;
  logic [1:0]    code_q;
  logic          page_ok, idle_cmd, go_clr, go_wr, go_rd, done;

  assign page_ok  = int'(page_i) < NUM_PAGES;
  assign idle_cmd = cmd_we_i && !busy_q;
  assign go_clr   = idle_cmd && (cmd_i == CMD_CLR);
  assign go_wr    = idle_cmd && (cmd_i == CMD_WR) && wen_i && page_ok;
  assign go_rd    = idle_cmd && (cmd_i == CMD_RD) && page_ok;
  assign done     = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_RD;
      cnt_q  <= '0;
      page_q <= '0;
      code_q <= '0;
    end else if (go_wr) begin
      busy_q <= 1'b1;
      op_q   <= OP_WR;
      cnt_q  <= CW'(WR_CYCLES - 1);
      page_q <= page_i[AW-1:0];
      code_q <= 2'b01;
    end else if (go_rd) begin
      busy_q <= 1'b1;
      op_q   <= OP_RD;
      cnt_q  <= CW'(RD_CYCLES - 1);
      page_q <= page_i[AW-1:0];
      code_q <= 2'b10;
    end else if (go_clr) begin
      code_q <= 2'b00;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a read discards leftovers at issue; a write empties the buffer once committed
  assign fifo_clr_o  = go_clr || go_rd || (done && op_q == OP_WR);
  assign fifo_load_o = done && op_q == OP_RD;
  assign store_we_o  = done && op_q == OP_WR;
  assign busy_o      = busy_q;
  assign op_o        = op_q;
  assign page_o      = page_q;
  assign code_o      = code_q;
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int NUM_PAGES  = 232,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 64,
  parameter int RD_CYCLES  = 32,
  localparam int AW        = $clog2(NUM_PAGES),
  localparam int PAGE_BITS = PAGE_BYTES * DW,
  localparam int PW        = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]        page_q;
  logic                 wen_q;
  logic                 busy, fifo_clr, fifo_load, store_we;
  op_e                  op;
  logic [AW-1:0]        page_lat;
  logic [1:0]           code;
  logic                 cmd_we, push, pop;
  logic [DW-1:0]        pop_data;
  logic [PAGE_BITS-1:0] fifo_flat, store_rdata;
  logic [PW-1:0]        fifo_wptr, fifo_rptr;

  assign cmd_we = wr_i && (reg_sel_e'(addr_i) == REG_CMD);
  assign push   = wr_i && (reg_sel_e'(addr_i) == REG_DATA) && !busy;
  assign pop    = rd_i && (reg_sel_e'(addr_i) == REG_DATA) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      wen_q  <= 1'b0;
    end else if (wr_i) begin
      if (reg_sel_e'(addr_i) == REG_PAGE) page_q <= wdata_i;
      if (reg_sel_e'(addr_i) == REG_MODE) wen_q  <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (reg_sel_e'(addr_i))
        REG_PAGE: rdata_o <= page_q;
        REG_CMD:  rdata_o <= {!busy, 5'b0, code};
        REG_MODE: rdata_o <= {7'b0, wen_q};
        REG_DATA: rdata_o <= busy ? '0 : pop_data;
        default:  rdata_o <= '0;
      endcase
    end
  end

  pgm_seq #(
    .NUM_PAGES(NUM_PAGES),
    .WR_CYCLES(WR_CYCLES),
    .RD_CYCLES(RD_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we),
    .cmd_i      (wdata_i),
    .wen_i      (wen_q),
    .page_i     (page_q),
    .busy_o     (busy),
    .op_o       (op),
    .page_o     (page_lat),
    .code_o     (code),
    .fifo_clr_o (fifo_clr),
    .fifo_load_o(fifo_load),
    .store_we_o (store_we)
  );

  pgm_fifo #(
    .DEPTH(PAGE_BYTES),
    .DW   (DW)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (fifo_clr),
    .load_i     (fifo_load),
    .load_data_i(store_rdata),
    .push_i     (push),
    .push_data_i(wdata_i),
    .pop_i      (pop),
    .pop_data_o (pop_data),
    .flat_o     (fifo_flat),
    .wptr_o     (fifo_wptr),
    .rptr_o     (fifo_rptr)
  );

  pgm_store #(
    .NUM_PAGES(NUM_PAGES),
    .PAGE_BITS(PAGE_BITS)
  ) u_store (
    .clk_i  (clk_i),
    .we_i   (store_we),
    .waddr_i(page_lat),
    .wdata_i(fifo_flat),
    .raddr_i(page_lat),
    .rdata_o(store_rdata)
  );
endmodule

// File: rtl/pgm_chk.sv
module pgm_chk #(
  parameter int NUM_PAGES  = 232,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 64,
  parameter int RD_CYCLES  = 32,
  localparam int AW        = $clog2(NUM_PAGES),
  localparam int PW        = $clog2(PAGE_BYTES + 1),
  localparam int MAXC      = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES,
  localparam int RW        = $clog2(MAXC + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    addr_i,
  input logic          rd_i,
  input logic [7:0]    rdata_o,
  input logic          busy_i,
  input logic          op_wr_i,
  input logic          wen_i,
  input logic [AW-1:0] page_lat_i,
  input logic          store_we_i,
  input logic [PW-1:0] wptr_i,
  input logic [PW-1:0] rptr_i
);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= (run_q == RW'(MAXC + 1)) ? run_q : run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(run_q) <= MAXC);

  // R6
  wen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && op_wr_i) |-> $past(wen_i));

  // R7
  page_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_i |-> (int'(page_lat_i) < NUM_PAGES));

  // R9
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(page_lat_i));

  // R10
  fill_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(wptr_i) <= PAGE_BYTES) && (rptr_i <= wptr_i));

  // R10
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3 && rptr_i == wptr_i) |=> (rdata_o == 8'h00));

  // R3
  commit_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_we_i |=> (!busy_i && wptr_i == '0));
endmodule

bind pgm_ctrl pgm_chk #(
  .NUM_PAGES (NUM_PAGES),
  .PAGE_BYTES(PAGE_BYTES),
  .WR_CYCLES (WR_CYCLES),
  .RD_CYCLES (RD_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .busy_i    (busy),
  .op_wr_i   (op == pgm_pkg::OP_WR),
  .wen_i     (wen_q),
  .page_lat_i(page_lat),
  .store_we_i(store_we),
  .wptr_i    (fifo_wptr),
  .rptr_i    (fifo_rptr)
);

// File: tb/tb_pgm_ctrl.sv
`timescale 1ns/1ps
module tb_pgm_ctrl;
  localparam int NP  = 232;
  localparam int PB  = 32;
  localparam int WRC = 64;
  localparam int RDC = 32;
  localparam logic [1:0] A_PAGE = 2'd0, A_CMD = 2'd1, A_MODE = 2'd2, A_DATA = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pgm_ctrl #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .WR_CYCLES(WRC), .RD_CYCLES(RDC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] pat(int p, int k, int v);
    return 8'(p * 7 + k * 29 + v * 101 + 3);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic bwr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic poll(output int zeros);
    logic [7:0] s;
    zeros = 0;
    for (int i = 0; i < 1000; i++) begin
      brd(A_CMD, s);
      if (s[7]) break;
      zeros++;
    end
  endtask

  task automatic fill(int p, int v, int cnt);
    bwr(A_CMD, 8'h00);
    for (int k = 0; k < cnt; k++) bwr(A_DATA, pat(p, k, v));
  endtask

  task automatic prog(int p, int exp_zeros, string tag);
    int z;
    bwr(A_PAGE, 8'(p));
    bwr(A_CMD, 8'h01);
    poll(z);
    chk(tag, z, exp_zeros);
  endtask

  task automatic fetch(int p, int v, int nfill, string tag);
    int z;
    logic [7:0] d;
    bwr(A_PAGE, 8'(p));
    bwr(A_CMD, 8'h02);
    poll(z);
    chk("R2 read busy length", z, RDC);
    for (int k = 0; k < PB; k++) begin
      brd(A_DATA, d);
      chk(tag, d, (k < nfill) ? pat(p, k, v) : 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    int z;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and map
    brd(A_PAGE, d); chk("R1 page reset", d, 8'h00);
    brd(A_CMD, d);  chk("R1 status reset", d, 8'h80);
    brd(A_MODE, d); chk("R1 mode reset", d, 8'h00);
    brd(A_DATA, d); chk("R1 data reset", d, 8'h00);
    bwr(A_PAGE, 8'hE7);
    brd(A_PAGE, d); chk("R1 page readback", d, 8'hE7);

    bwr(A_MODE, 8'h01);
    brd(A_MODE, d); chk("R6 mode enable", d, 8'h01);

    // R3 R2: program every page; last one disables mode right after issue (R6)
    for (int p = 0; p < NP; p++) begin
      fill(p, 0, PB);
      if (p == NP - 1) begin
        bwr(A_PAGE, 8'(p));
        bwr(A_CMD, 8'h01);
        bwr(A_MODE, 8'h00);
        poll(z);
        chk("R6 disable after issue busy", z, WRC - 1);
      end else begin
        prog(p, WRC, "R2 write busy length");
      end
    end
    brd(A_CMD, d); chk("R5 code after write", d, 8'h81);

    // R4 fetch every page
    for (int p = 0; p < NP; p++) fetch(p, 0, PB, "R4 page data");
    brd(A_CMD, d);  chk("R5 code after read", d, 8'h82);
    brd(A_DATA, d); chk("R10 read past drained page", d, 8'h00);
    bwr(A_CMD, 8'h00);
    brd(A_CMD, d);  chk("R5 code cleared", d, 8'h80);
    brd(A_DATA, d); chk("R10 empty read", d, 8'h00);

    // R6 write with mode off is ignored
    fill(3, 1, PB);
    bwr(A_PAGE, 8'd3);
    bwr(A_CMD, 8'h01);
    brd(A_CMD, d); chk("R6 gated write ready", d, 8'h80);
    fetch(3, 0, PB, "R6 page unchanged");

    // R7 out-of-range write: ignored, buffer kept, then committed to 231
    bwr(A_MODE, 8'h01);
    fill(231, 1, PB);
    bwr(A_PAGE, 8'd232);
    bwr(A_CMD, 8'h01);
    brd(A_CMD, d); chk("R7 write page 232 ignored", d, 8'h80);
    prog(231, WRC, "R2 write busy length");
    fetch(231, 1, PB, "R7 buffer kept");

    // R7 out-of-range read: buffer not reloaded
    bwr(A_PAGE, 8'd231);
    bwr(A_CMD, 8'h02);
    poll(z);
    for (int k = 0; k < 3; k++) brd(A_DATA, d);
    bwr(A_PAGE, 8'hFF);
    bwr(A_CMD, 8'h02);
    brd(A_CMD, d);  chk("R7 read page 255 ignored", d, 8'h82);
    brd(A_DATA, d); chk("R7 buffer position kept", d, pat(231, 3, 1));

    // R8 R9 R12: command and data while busy, page changed mid-operation
    fill(10, 1, PB);
    bwr(A_PAGE, 8'd10);
    bwr(A_CMD, 8'h01);
    bwr(A_PAGE, 8'd20);
    bwr(A_CMD, 8'h02);
    brd(A_DATA, d); chk("R12 data read while busy", d, 8'h00);
    poll(z); chk("R8 busy not extended", z, WRC - 3);
    brd(A_CMD, d);  chk("R8 busy command ignored", d, 8'h81);
    brd(A_PAGE, d); chk("R9 register updated", d, 8'd20);
    fetch(10, 1, PB, "R9 latched page written");
    fetch(20, 0, PB, "R9 other page untouched");

    // R8 unknown code
    bwr(A_CMD, 8'h03);
    brd(A_CMD, d); chk("R8 unknown code ignored", d, 8'h82);

    // R10 overflow push dropped
    fill(7, 2, PB);
    bwr(A_DATA, 8'hAA);
    prog(7, WRC, "R2 write busy length");
    fetch(7, 2, PB, "R10 overflow dropped");

    // R11 aborted read restarts from byte 0
    bwr(A_PAGE, 8'd4);
    bwr(A_CMD, 8'h02);
    poll(z);
    for (int k = 0; k < 10; k++) brd(A_DATA, d);
    fetch(4, 0, PB, "R11 aborted read restart");

    // R11 partial fill programs zeros in unfilled slots, buffer emptied
    fill(9, 2, 5);
    prog(9, WRC, "R2 write busy length");
    brd(A_DATA, d); chk("R11 buffer empty after write", d, 8'h00);
    fetch(9, 2, 5, "R11 partial page");

    // R12 push during read busy is ignored
    bwr(A_PAGE, 8'd5);
    bwr(A_CMD, 8'h02);
    bwr(A_DATA, 8'h55);
    brd(A_DATA, d); chk("R12 data read while read busy", d, 8'h00);
    poll(z); chk("R12 read busy length", z, RDC - 2);
    for (int k = 0; k < PB; k++) begin
      brd(A_DATA, d);
      chk("R12 page after busy push", d, pat(5, k, 0));
    end
    brd(A_DATA, d); chk("R12 no extra byte", d, 8'h00);

    summary();
  end
endmodule